// File: doc/BRIEF.md
# Banked Register File Address Generator

This block turns a data-memory operand from an 8-bit core into a physical register-file address. The register file has four banks of 128 bytes each. A direct operand of 7 bits is placed under a 2-bit direct bank select. An operand of offset 0 is the indirect data location, which is not a real register: the access goes through an 8-bit pointer, with a separate 1-bit indirect bank select as address bit 8. The result carries three flags. One says the location reads as zero and ignores writes. One says the location is a core register mirrored into every bank. One says the address came through the pointer.

Each request carries the operand, both bank selects and the pointer, and enters on a valid/ready channel. A result leaves one cycle later on a second valid/ready channel. The input accepts a request when `in_ready` is high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the result stays in place unchanged and no new request is taken. The register file uses the mirrored flag to map every bank's copy of a core register to one storage location. It uses the hole flag to return zero on a read and to drop a write.

Top module: `regbank_addr_gen`

## Requirements
- R1: With a nonzero operand, `out_addr` is `{in_dir_bank, in_ofs}` (bank 0 → 000h–07Fh, 1 → 080h–0FFh, 2 → 100h–17Fh, 3 → 180h–1FFh), and `out_via_ptr` is 0.
- R2: With operand 0, `out_via_ptr` is 1 and the address is `{in_ind_bank, in_ptr}`: bank bit 0 reaches 000h–0FFh and bank bit 1 reaches 100h–1FFh.
- R3: If an access through the pointer lands on offset 0 of any bank (pointer bits 6:0 all zero), `out_hole` is 1 and `out_shared` is 0. Such a location therefore reads as zero and ignores writes, and the lookup does not recurse.
- R4: Offsets 02h, 03h, 04h, 0Ah and 0Bh are mirrored core registers in every bank. Whether reached directly or through the pointer, they give `out_shared`=1, `out_hole`=0 and an address with bits 8:7 cleared.
- R5: In banks 2 and 3, offsets 05h, 07h, 08h and 09h are unimplemented and give `out_hole`=1. In banks 0 and 1 these offsets give `out_hole`=0.
- R6: Offset 06h is a separate, non-mirrored, implemented register in each bank, at 006h, 086h, 106h and 186h.
- R7: A request is taken on a clock edge with `in_valid` and `in_ready` both high, and its result shows on the outputs with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold their values.
- R9: While `rst_n` is low, `out_valid` is 0.
- R10: A direct access ignores `in_ind_bank`, and an access through the pointer ignores `in_dir_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_ofs | input | 7 | Direct operand offset from the instruction |
| in_dir_bank | input | 2 | Direct bank select (status bits 6:5, reset 0) |
| in_ind_bank | input | 1 | Indirect bank select (status bit 7, reset 0) |
| in_ptr | input | 8 | Indirect pointer register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 9 | Physical register-file address |
| out_hole | output | 1 | Location reads as zero, writes ignored |
| out_shared | output | 1 | Mirrored core register, address canonical to bank 0 |
| out_via_ptr | output | 1 | Address was formed through the pointer |

## Verification
The bench builds the block with its default parameters: four banks of 128 bytes, a 16-entry window for special registers, the mirror mask for the five core registers, and a hole map that marks the four unimplemented offsets in the two upper banks only. With these values a short directed list covers every bank. It also reaches the pointer-to-offset-0 case from both indirect halves, mirrored registers reached through the pointer, and holes reached both directly and through the pointer. A long random phase with random back-pressure then exercises the stall and pass-through rules of the handshake against a queue model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Outcome of bank selection, before the map lookup
  typedef struct packed {
    logic       via_ptr;   // address formed through the pointer
    logic       nul;       // pointer landed on an indirect slot again
  } resolve_flags_t;

  // Flags attached to each result
  typedef struct packed {
    logic       hole;
    logic       shared;
    logic       via_ptr;
  } map_flags_t;

  localparam int unsigned FLAG_W = $bits(map_flags_t);

endpackage

// File: rtl/regbank_resolve.sv
// Picks between direct and indirect address formation.
module regbank_resolve
  import regbank_pkg::*;
#(
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned ADDR_W = OFS_W + BANK_W,
  localparam int unsigned PTR_W  = ADDR_W - 1
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [BANK_W-1:0] dir_bank_i,
  input  logic              ind_bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output resolve_flags_t    flags_o
);

  logic              is_indirect;
  logic [ADDR_W-1:0] direct_addr;
  logic [ADDR_W-1:0] pointer_addr;

  assign is_indirect  = (ofs_i == '0);
  assign direct_addr  = {dir_bank_i, ofs_i};
  assign pointer_addr = {ind_bank_i, ptr_i};

  always_comb begin
    flags_o = '0;
    if (is_indirect) begin
      addr_o          = pointer_addr;
      flags_o.via_ptr = 1'b1;
      // a second indirect slot would recurse: mark it empty instead
      flags_o.nul     = (pointer_addr[OFS_W-1:0] == '0);
    end else begin
      addr_o          = direct_addr;
    end
  end

endmodule

// File: rtl/regbank_classify.sv
// Looks the resolved address up in the mirror mask and the per-bank hole map.
module regbank_classify
  import regbank_pkg::*;
#(
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned SFR_SPAN = 16,
  parameter logic [SFR_SPAN-1:0] SHARED_MASK = 16'h0C1C,
  parameter logic [(2**BANK_W)*SFR_SPAN-1:0] HOLE_MAP = 64'h03A0_03A0_0000_0000,
  localparam int unsigned ADDR_W = OFS_W + BANK_W,
  localparam int unsigned NBANKS = 2**BANK_W,
  localparam int unsigned SPAN_W = (SFR_SPAN > 1) ? $clog2(SFR_SPAN) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  resolve_flags_t    rflags_i,
  output logic [ADDR_W-1:0] addr_o,
  output map_flags_t        flags_o
);

  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] bank;
  logic              in_win;
  logic [SPAN_W-1:0] win_idx;
  logic [NBANKS-1:0] bank_hole;
  logic              mirrored;

  assign ofs     = addr_i[OFS_W-1:0];
  assign bank    = addr_i[ADDR_W-1:OFS_W];
  assign in_win  = (ofs < OFS_W'(SFR_SPAN));
  assign win_idx = ofs[SPAN_W-1:0];

  // one hole decoder per bank
  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [SFR_SPAN-1:0] row;
      assign row          = HOLE_MAP[b*SFR_SPAN +: SFR_SPAN];
      assign bank_hole[b] = (bank == BANK_W'(b)) && in_win && row[win_idx];
    end
  endgenerate

  assign mirrored = in_win && SHARED_MASK[win_idx] && !rflags_i.nul;

  always_comb begin
    flags_o.via_ptr = rflags_i.via_ptr;
    flags_o.shared  = mirrored;
    flags_o.hole    = rflags_i.nul || (|bank_hole);
    addr_o          = mirrored ? {{BANK_W{1'b0}}, ofs} : addr_i;
  end

endmodule

// File: rtl/regbank_stage.sv
// One-entry valid/ready register slice.
module regbank_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (in_ready) begin
      full_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      data_q <= in_data;
    end
  end

endmodule

// File: rtl/regbank_addr_gen.sv
module regbank_addr_gen
  import regbank_pkg::*;
#(
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned SFR_SPAN = 16,
  parameter logic [SFR_SPAN-1:0] SHARED_MASK = 16'h0C1C,
  parameter logic [(2**BANK_W)*SFR_SPAN-1:0] HOLE_MAP = 64'h03A0_03A0_0000_0000,
  localparam int unsigned ADDR_W = OFS_W + BANK_W,
  localparam int unsigned PTR_W  = ADDR_W - 1,
  localparam int unsigned PAY_W  = ADDR_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic [BANK_W-1:0] in_dir_bank,
  input  logic              in_ind_bank,
  input  logic [PTR_W-1:0]  in_ptr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hole,
  output logic              out_shared,
  output logic              out_via_ptr
);

  logic [ADDR_W-1:0] res_addr;
  resolve_flags_t    res_flags;
  logic [ADDR_W-1:0] map_addr;
  map_flags_t        map_flags;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;
  map_flags_t        out_flags;

  regbank_resolve #(
    .OFS_W  (OFS_W),
    .BANK_W (BANK_W)
  ) u_resolve (
    .ofs_i      (in_ofs),
    .dir_bank_i (in_dir_bank),
    .ind_bank_i (in_ind_bank),
    .ptr_i      (in_ptr),
    .addr_o     (res_addr),
    .flags_o    (res_flags)
  );

  regbank_classify #(
    .OFS_W       (OFS_W),
    .BANK_W      (BANK_W),
    .SFR_SPAN    (SFR_SPAN),
    .SHARED_MASK (SHARED_MASK),
    .HOLE_MAP    (HOLE_MAP)
  ) u_classify (
    .addr_i   (res_addr),
    .rflags_i (res_flags),
    .addr_o   (map_addr),
    .flags_o  (map_flags)
  );

  assign pay_in = {map_addr, map_flags};

  regbank_stage #(
    .W (PAY_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_flags   = pay_out[FLAG_W-1:0];
  assign out_addr    = pay_out[PAY_W-1:FLAG_W];
  assign out_hole    = out_flags.hole;
  assign out_shared  = out_flags.shared;
  assign out_via_ptr = out_flags.via_ptr;

endmodule

// File: rtl/regbank_addr_gen_chk.sv
module regbank_addr_gen_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFS_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_hole,
  input logic              out_shared,
  input logic              out_via_ptr
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_STALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R8

  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_addr) && $stable(out_hole)
      && $stable(out_shared) && $stable(out_via_ptr)); // R8

  AST_NULL_IS_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_via_ptr && out_addr[OFS_W-1:0] == '0
      |-> out_hole && !out_shared); // R3

  AST_SHARED_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_shared |-> out_addr[ADDR_W-1:OFS_W] == '0 && !out_hole); // R4

  AST_LOW_NO_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_via_ptr && !out_addr[ADDR_W-1] |-> !out_hole); // R5

endmodule

bind regbank_addr_gen regbank_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_hole    (out_hole),
  .out_shared  (out_shared),
  .out_via_ptr (out_via_ptr)
);

// File: tb/regbank_addr_gen_tb.sv
module regbank_addr_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [6:0] in_ofs = '0;
  logic [1:0] in_dir_bank = '0;
  logic       in_ind_bank = 1'b0;
  logic [7:0] in_ptr = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [8:0] out_addr;
  logic       out_hole;
  logic       out_shared;
  logic       out_via_ptr;

  always #10 clk = ~clk; // 50 MHz

  regbank_addr_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_ofs      (in_ofs),
    .in_dir_bank (in_dir_bank),
    .in_ind_bank (in_ind_bank),
    .in_ptr      (in_ptr),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_hole    (out_hole),
    .out_shared  (out_shared),
    .out_via_ptr (out_via_ptr)
  );

  typedef struct {
    int    addr;
    bit    hole;
    bit    shared;
    bit    via;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural model of the address map
  function automatic exp_t model(int ofs, int ind, int dir, int ptr);
    exp_t e;
    int   a, o, b;
    bit   nul;
    e.via = (ofs == 0);
    if (e.via) a = ind * 256 + ptr;
    else       a = dir * 128 + ofs;
    o   = a % 128;
    b   = a / 128;
    nul = e.via && (o == 0);
    e.shared = !nul && (o == 2 || o == 3 || o == 4 || o == 10 || o == 11);
    e.hole   = nul || (b >= 2 && (o == 5 || o == 7 || o == 8 || o == 9));
    e.addr   = e.shared ? o : a;
    if (nul)                          e.tag = "R3";
    else if (e.shared)                e.tag = "R4";
    else if (o >= 5 && o <= 9 && o != 6) e.tag = "R5";
    else if (o == 6)                  e.tag = "R6";
    else if (e.via && dir != 0)       e.tag = "R10";
    else if (!e.via && ind != 0)      e.tag = "R10";
    else if (e.via)                   e.tag = "R2";
    else                              e.tag = "R1";
    return e;
  endfunction

  task automatic step(bit v, int ofs, int ind, int dir, int ptr, bit rdy);
    @(negedge clk);
    in_valid    = v;
    in_ofs      = 7'(ofs);
    in_ind_bank = ind[0];
    in_dir_bank = 2'(dir);
    in_ptr      = 8'(ptr);
    out_ready   = rdy;
    #1;
    chk(out_valid == (q.size() != 0), "R7", "out_valid", int'(out_valid), int'(q.size() != 0));
    if (out_valid && q.size() != 0) begin
      chk(int'(out_addr) == q[0].addr, q[0].tag, "addr", int'(out_addr), q[0].addr);
      chk(out_hole == q[0].hole, q[0].tag, "hole", int'(out_hole), int'(q[0].hole));
      chk(out_shared == q[0].shared, q[0].tag, "shared", int'(out_shared), int'(q[0].shared));
      chk(out_via_ptr == q[0].via, q[0].tag, "via_ptr", int'(out_via_ptr), int'(q[0].via));
    end
    chk(in_ready == (q.size() == 0 || rdy), "R7", "in_ready", int'(in_ready),
        int'(q.size() == 0 || rdy));
    if (out_valid && rdy && q.size() != 0) void'(q.pop_front());
    if (v && in_ready) q.push_back(model(ofs, ind, dir, ptr));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    // R9: idle under reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;

    // R1 direct, every bank
    for (int b = 0; b < 4; b++) step(1, 'h25, 0, b, 0, 1);
    // R2 indirect, both halves
    step(1, 0, 0, 0, 'h45, 1);
    step(1, 0, 1, 0, 'hC5, 1);
    // R3 pointer back to an indirect slot
    step(1, 0, 0, 0, 'h00, 1);
    step(1, 0, 1, 0, 'h80, 1);
    step(1, 0, 1, 2, 'h00, 1);
    // R4 mirrored, directly and through the pointer
    step(1, 3, 0, 2, 0, 1);
    step(1, 'h0B, 0, 3, 0, 1);
    step(1, 2, 0, 1, 0, 1);
    step(1, 0, 0, 0, 'h83, 1);
    step(1, 0, 1, 0, 'h0A, 1);
    // R5 holes in the upper banks only
    for (int b = 0; b < 4; b++) begin
      step(1, 5, 0, b, 0, 1);
      step(1, 7, 0, b, 0, 1);
      step(1, 8, 0, b, 0, 1);
      step(1, 9, 0, b, 0, 1);
    end
    step(1, 0, 1, 0, 'h05, 1);
    // R6 offset 6 per bank
    for (int b = 0; b < 4; b++) step(1, 6, 0, b, 0, 1);
    step(1, 0, 1, 0, 'h86, 1);
    // R10 foreign bank bits ignored
    step(1, 'h30, 1, 1, 'hFF, 1);
    step(1, 0, 0, 3, 'h31, 1);
    // R8 stall: hold a result, then drain
    step(1, 'h12, 0, 2, 0, 0);
    step(1, 'h13, 0, 2, 0, 0);
    step(1, 'h14, 0, 2, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);

    // random traffic with random back-pressure (R7, R8 and the map)
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      step(($urandom_range(0, 3) != 0),
           (r == 0) ? 0 : ((r == 1) ? $urandom_range(1, 15) : $urandom_range(1, 127)),
           $urandom_range(0, 1), $urandom_range(0, 3),
           ($urandom_range(0, 3) == 0) ? ($urandom_range(0, 1) * 128) : $urandom_range(0, 255),
           ($urandom_range(0, 2) != 0));
    end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
    finish_run();
  end

endmodule